// File: doc/BRIEF.md
# Palette DAC Index/Data Port

This block is the host-side access path of a colour palette. One 32-bit register window is split into four byte lanes: a write index, a data port, a pixel mask and a read index. Software first selects an entry by writing one of the indices. It then moves colour components through the data lane one byte at a time, in the order red, green, blue.

Data writes are ANDed with the mask and gathered in a component buffer. The third write stores the full entry into a palette RAM at the write index, and the index then advances. A data read at the start of a triplet fetches the entry at the read index into the same buffer. Successive data reads return red, green and blue, and the read index advances after blue. A single counter tracks the position within the triplet for both directions. It returns to zero whenever either index is written. A second, read-only RAM port serves the video lookup path.

Top module: `pal_dac_port`

## Requirements
- R1: After reset the write index and read index are 0, the mask is 0xFF, the component counter is 0 and no response is pending.
- R2: An access selects its lane with `req_lane` (0 write index, 1 data, 2 mask, 3 read index). A write takes the byte at bits [8*lane+7:8*lane] of `req_wdata` and ignores the other bytes. A read returns the lane's byte at the same position, with all other bits zero.
- R3: Each data-lane write stores the written byte ANDed with the current mask into the buffer slot selected by the counter.
- R4: The third data write stores the entry {red, green, blue} at the write index, increments the write index and returns the counter to 0.
- R5: A write to the write-index lane or the read-index lane returns the component counter to 0, which discards any partly collected triplet.
- R6: A data read with the counter at 0 loads the entry at the read index into the buffer. That read and the next two return red, green and blue in turn.
- R7: After the third data read the read index increments and the counter returns to 0.
- R8: Both indices wrap from 255 to 0 when they increment.
- R9: `rsp_valid` is high in exactly the cycle after a read request, and is low after writes and idle cycles.
- R10: `vid_color` shows the palette entry at `vid_idx` one cycle after the index is applied, packed with red in bits [23:16] and blue in bits [7:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lane | input | 2 | Byte lane addressed by the access |
| req_wdata | input | 32 | Write data; only the addressed lane's byte is used |
| rsp_valid | output | 1 | Read data valid (one cycle after the read) |
| rsp_rdata | output | 32 | Read data, byte in its lane position |
| vid_idx | input | 8 | Video lookup index |
| vid_color | output | 24 | Palette entry for the video lookup |

## Verification
The bench uses the defaults: 8-bit indices, so the palette has 256 entries, with 8-bit components and three components per entry. With these values the wrap from 255 to 0 can be reached in a few accesses, by loading 255 into an index directly rather than stepping through the whole palette. A narrow mask shows that masking is applied per component. Back-to-back data reads exercise the cycle in which a freshly fetched entry is both returned and captured into the buffer.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;
  typedef enum logic [1:0] {
    LANE_WIDX = 2'd0,
    LANE_DATA = 2'd1,
    LANE_MASK = 2'd2,
    LANE_RIDX = 2'd3
  } lane_e;
endpackage

// File: rtl/pal_dac_ram.sv
module pal_dac_ram #(
  parameter int AW = 8,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_q,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    a_q <= mem[a_addr];
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/pal_dac_seq.sv
module pal_dac_seq
  import pal_dac_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  parameter int NCOMP  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [1:0]              req_lane,
  input  logic [4*COMP_W-1:0]     req_wdata,
  input  logic [NCOMP*COMP_W-1:0] ram_q,
  output logic                    ram_we,
  output logic [IDX_W-1:0]        ram_waddr,
  output logic [NCOMP*COMP_W-1:0] ram_wdata,
  output logic [IDX_W-1:0]        ram_raddr,
  output logic                    rsp_valid,
  output logic [4*COMP_W-1:0]     rsp_rdata
);
  localparam int ENT_W = NCOMP * COMP_W;
  localparam int BUS_W = 4 * COMP_W;
  localparam int CNT_W = $clog2(NCOMP);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NCOMP - 1);

  logic [IDX_W-1:0]  widx, ridx;
  logic [COMP_W-1:0] mask;
  logic [CNT_W-1:0]  cnt;
  logic              pend;
  logic [1:0]        rsp_lane;
  logic [COMP_W-1:0] rsp_byte;
  logic [COMP_W-1:0] buf_q   [NCOMP];
  logic [COMP_W-1:0] buf_src [NCOMP];
  logic [COMP_W-1:0] lane_byte, mbyte, out_byte;

  assign lane_byte = req_wdata[req_lane*COMP_W +: COMP_W];
  assign mbyte     = lane_byte & mask;

  wire wr_acc  = req_valid && req_write;
  wire rd_acc  = req_valid && !req_write;
  wire wr_data = wr_acc && (req_lane == LANE_DATA);
  wire rd_data = rd_acc && (req_lane == LANE_DATA);

  // Buffer view: freshly fetched entry takes over the cycle after the fetch
  for (genvar k = 0; k < NCOMP; k++) begin : g_src
    assign buf_src[k] = pend ? ram_q[(NCOMP-1-k)*COMP_W +: COMP_W] : buf_q[k];
    if (k == NCOMP - 1) begin : g_last
      assign ram_wdata[(NCOMP-1-k)*COMP_W +: COMP_W] = mbyte;
    end else begin : g_prev
      assign ram_wdata[(NCOMP-1-k)*COMP_W +: COMP_W] = buf_src[k];
    end
  end

  assign ram_we    = wr_data && (cnt == LAST);
  assign ram_waddr = widx;
  assign ram_raddr = ridx;

  assign out_byte  = pend ? ram_q[ENT_W-1 -: COMP_W] : rsp_byte;
  assign rsp_rdata = BUS_W'(out_byte) << (rsp_lane * COMP_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      widx      <= '0;
      ridx      <= '0;
      mask      <= '1;
      cnt       <= '0;
      pend      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_lane  <= '0;
      rsp_byte  <= '0;
    end else begin
      pend      <= 1'b0;
      rsp_valid <= 1'b0;
      if (pend) begin
        for (int k = 0; k < NCOMP; k++)
          buf_q[k] <= ram_q[(NCOMP-1-k)*COMP_W +: COMP_W];
      end
      if (wr_acc) begin
        case (req_lane)
          LANE_WIDX: begin widx <= lane_byte[IDX_W-1:0]; cnt <= '0; end
          LANE_RIDX: begin ridx <= lane_byte[IDX_W-1:0]; cnt <= '0; end
          LANE_MASK: mask <= lane_byte;
          default: begin
            if (cnt == LAST) begin
              widx <= widx + 1'b1;
              cnt  <= '0;
            end else begin
              buf_q[cnt] <= mbyte;
              cnt        <= cnt + 1'b1;
            end
          end
        endcase
      end else if (rd_acc) begin
        rsp_valid <= 1'b1;
        rsp_lane  <= req_lane;
        case (req_lane)
          LANE_WIDX: rsp_byte <= COMP_W'(widx);
          LANE_RIDX: rsp_byte <= COMP_W'(ridx);
          LANE_MASK: rsp_byte <= mask;
          default: begin
            pend     <= (cnt == '0);
            rsp_byte <= buf_src[cnt];
            if (cnt == LAST) begin
              ridx <= ridx + 1'b1;
              cnt  <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        endcase
      end
    end
  end

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  assert_commit_advance_R4: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> (widx == IDX_W'($past(widx) + 1'b1)) && (cnt == '0));

  assert_index_clears_cnt_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && (req_lane == LANE_WIDX || req_lane == LANE_RIDX)) |=> (cnt == '0));

  assert_read_advance_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_data && cnt == LAST) |=> (ridx == IDX_W'($past(ridx) + 1'b1)) && (cnt == '0));

  assert_fetch_flag_R6: assert property (@(posedge clk) disable iff (rst)
    pend |-> rsp_valid && (rsp_lane == LANE_DATA));
endmodule

// File: rtl/pal_dac_port.sv
module pal_dac_port #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  parameter int NCOMP  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [1:0]              req_lane,
  input  logic [4*COMP_W-1:0]     req_wdata,
  output logic                    rsp_valid,
  output logic [4*COMP_W-1:0]     rsp_rdata,
  input  logic [IDX_W-1:0]        vid_idx,
  output logic [NCOMP*COMP_W-1:0] vid_color
);
  localparam int ENT_W = NCOMP * COMP_W;

  logic             ram_we;
  logic [IDX_W-1:0] ram_waddr, ram_raddr;
  logic [ENT_W-1:0] ram_wdata, ram_q;

  pal_dac_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W), .NCOMP(NCOMP)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_lane(req_lane), .req_wdata(req_wdata),
    .ram_q(ram_q), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata), .ram_raddr(ram_raddr),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  pal_dac_ram #(.AW(IDX_W), .DW(ENT_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .a_addr(ram_raddr), .a_q(ram_q),
    .b_addr(vid_idx), .b_q(vid_color)
  );

  assert_rsp_follows_read_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid);

  assert_rsp_only_after_read_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_write));
endmodule

// File: tb/pal_dac_port_test.sv
module pal_dac_port_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [1:0]  req_lane;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [7:0]  vid_idx;
  logic [23:0] vid_color;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pal_dac_port uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_lane(req_lane), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .vid_idx(vid_idx), .vid_color(vid_color)
  );

  // {read, lane, write byte, expected byte, requirement number}
  localparam int NV = 36;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'h10, 8'h00, 4'd2},  // R2 write index 0x10
    {1'b0, 2'd1, 8'h11, 8'h00, 4'd4},  // R4 red
    {1'b0, 2'd1, 8'h22, 8'h00, 4'd4},  // R4 green
    {1'b0, 2'd1, 8'h33, 8'h00, 4'd4},  // R4 blue, commit
    {1'b1, 2'd0, 8'h00, 8'h11, 4'd4},  // R4 write index advanced
    {1'b0, 2'd3, 8'h10, 8'h00, 4'd2},  // R2 read index 0x10
    {1'b1, 2'd3, 8'h00, 8'h10, 4'd2},  // R2 read index readback
    {1'b1, 2'd1, 8'h00, 8'h11, 4'd6},  // R6 red (fetch)
    {1'b1, 2'd1, 8'h00, 8'h22, 4'd6},  // R6 green
    {1'b1, 2'd1, 8'h00, 8'h33, 4'd6},  // R6 blue
    {1'b1, 2'd3, 8'h00, 8'h11, 4'd7},  // R7 read index advanced
    {1'b0, 2'd2, 8'h0F, 8'h00, 4'd3},  // R3 mask 0x0F
    {1'b1, 2'd2, 8'h00, 8'h0F, 4'd2},  // R2 mask readback
    {1'b0, 2'd1, 8'hAB, 8'h00, 4'd3},  // R3
    {1'b0, 2'd1, 8'hCD, 8'h00, 4'd3},  // R3
    {1'b0, 2'd1, 8'hEF, 8'h00, 4'd3},  // R3 commit at 0x11
    {1'b1, 2'd1, 8'h00, 8'h0B, 4'd3},  // R3 masked red
    {1'b1, 2'd1, 8'h00, 8'h0D, 4'd3},  // R3 masked green
    {1'b1, 2'd1, 8'h00, 8'h0F, 4'd3},  // R3 masked blue
    {1'b1, 2'd0, 8'h00, 8'h12, 4'd4},  // R4
    {1'b0, 2'd1, 8'h05, 8'h00, 4'd5},  // R5 partial triplet
    {1'b0, 2'd0, 8'h20, 8'h00, 4'd5},  // R5 write index clears counter
    {1'b0, 2'd1, 8'h01, 8'h00, 4'd5},  // R5
    {1'b0, 2'd1, 8'h02, 8'h00, 4'd5},  // R5
    {1'b0, 2'd1, 8'h03, 8'h00, 4'd5},  // R5 commit at 0x20
    {1'b1, 2'd0, 8'h00, 8'h21, 4'd5},  // R5 only one commit occurred
    {1'b0, 2'd3, 8'h20, 8'h00, 4'd5},  // R5
    {1'b1, 2'd1, 8'h00, 8'h01, 4'd6},  // R6
    {1'b0, 2'd3, 8'h20, 8'h00, 4'd5},  // R5 read index clears counter
    {1'b1, 2'd1, 8'h00, 8'h01, 4'd5},  // R5 refetch red
    {1'b1, 2'd1, 8'h00, 8'h02, 4'd6},  // R6
    {1'b1, 2'd1, 8'h00, 8'h03, 4'd6},  // R6
    {1'b1, 2'd3, 8'h00, 8'h21, 4'd7},  // R7
    {1'b0, 2'd3, 8'h11, 8'h00, 4'd2},  // R2
    {1'b1, 2'd1, 8'h00, 8'h0B, 4'd6},  // R6 entry 0x11 still intact
    {1'b1, 2'd1, 8'h00, 8'h0D, 4'd6}   // R6
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Drives one access at a falling edge; checks the result at the next one.
  task automatic access(input bit rd, input logic [1:0] ln, input logic [7:0] d,
                        input logic [7:0] ex, input string tag);
    logic [31:0] w;
    w = 32'hA5A5A5A5;
    w[ln*8 +: 8] = d;
    req_valid = 1'b1;
    req_write = !rd;
    req_lane  = ln;
    req_wdata = w;
    @(negedge clk);
    req_valid = 1'b0;
    if (rd) begin
      chk(rsp_valid === 1'b1, {tag, " R9 valid"}, 32'(rsp_valid), 32'd1);
      chk(rsp_rdata === (32'(ex) << (8*ln)), tag, rsp_rdata, 32'(ex) << (8*ln));
    end else begin
      chk(rsp_valid === 1'b0, {tag, " R9 no rsp"}, 32'(rsp_valid), 32'd0);
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_lane = 2'd0;
    req_wdata = '0; vid_idx = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rsp_valid === 1'b0, "R1 idle", 32'(rsp_valid), 32'd0);
    access(1'b1, 2'd0, 8'h00, 8'h00, "R1 write index");
    access(1'b1, 2'd2, 8'h00, 8'hFF, "R1 mask");
    access(1'b1, 2'd3, 8'h00, 8'h00, "R1 read index");

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][22], VEC[i][21:20], VEC[i][19:12], VEC[i][11:4],
             $sformatf("R%0d vec%0d", VEC[i][3:0], i));
    end
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R9 idle", 32'(rsp_valid), 32'd0);

    // R10 video port
    vid_idx = 8'h10;
    @(negedge clk);
    chk(vid_color === 24'h112233, "R10 entry 0x10", 32'(vid_color), 32'h112233);
    vid_idx = 8'h11;
    @(negedge clk);
    chk(vid_color === 24'h0B0D0F, "R10 entry 0x11", 32'(vid_color), 32'h0B0D0F);

    // R8 write index wrap
    access(1'b0, 2'd2, 8'hFF, 8'h00, "R8 mask");
    access(1'b0, 2'd0, 8'hFF, 8'h00, "R8");
    access(1'b0, 2'd1, 8'hC1, 8'h00, "R8");
    access(1'b0, 2'd1, 8'hC2, 8'h00, "R8");
    access(1'b0, 2'd1, 8'hC3, 8'h00, "R8");
    access(1'b1, 2'd0, 8'h00, 8'h00, "R8 write index wrapped");
    // R8 read index wrap
    access(1'b0, 2'd3, 8'hFF, 8'h00, "R8");
    access(1'b1, 2'd1, 8'h00, 8'hC1, "R8 R6");
    access(1'b1, 2'd1, 8'h00, 8'hC2, "R8 R6");
    access(1'b1, 2'd1, 8'h00, 8'hC3, "R8 R6");
    access(1'b1, 2'd3, 8'h00, 8'h00, "R8 read index wrapped");
    vid_idx = 8'hFF;
    @(negedge clk);
    chk(vid_color === 24'hC1C2C3, "R10 entry 0xFF", 32'(vid_color), 32'hC1C2C3);

    // R1 reset after activity
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(rsp_valid === 1'b0, "R1 no rsp", 32'(rsp_valid), 32'd0);
    access(1'b1, 2'd0, 8'h00, 8'h00, "R1 write index");
    access(1'b1, 2'd3, 8'h00, 8'h00, "R1 read index");
    access(1'b1, 2'd2, 8'h00, 8'hFF, "R1 mask");
    access(1'b0, 2'd3, 8'h10, 8'h00, "R1");
    access(1'b1, 2'd1, 8'h00, 8'h11, "R1 counter at 0");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule